// File: doc/BRIEF.md
# Time-Slot Hub Arbiter with Spare-Slot Reclaim

Eight requesters share one memory port through a fixed time-division wheel. A free-running slot counter steps through eight slots, one per clock, and each requester owns exactly one of them. If the owner of the current slot is requesting, it gets the slot. If it is not, the slot counts as spare. A spare slot can go to another requester, but only to one that has set its reclaim-enable bit.

Requesters that leave their reclaim bit at 0 (compliant) keep pure time-division timing, whatever the others do. Requesters with the bit at 1 (reclaimers) share the spare slots among themselves in a rotating order. A global reclaim-disable input turns every requester compliant, which gives plain time-division grants for timing tests.

Each grant is registered, one-hot, and comes out together with the index of the slot it was made for. A flag marks grants that went to someone other than the slot's owner.

Top module: `hub_slot_arbiter`

## Requirements
- R1: `slot_o` steps 0,1,…,7,0,… by one each clock. It is the slot index that the decision presented on `grant_o` and `reclaimed_o` in the same cycle was made for. The decision for the first clock edge after reset is for slot 0.
- R2: If the owner of a slot requests (`req_i[s]` high, where requester s owns slot s), it receives that slot's grant, whatever the reclaim settings are.
- R3: `grant_o` is zero or one-hot, with bit i meaning requester i. It appears one clock after the `req_i`, `reclaim_en_i` and `reclaim_off_i` values it was decided from.
- R4: A requester whose `reclaim_en_i` bit is 0 is granted only in its own slot. A spare slot for which no reclaimer is requesting yields an all-zero grant.
- R5: A spare slot goes to a requesting reclaimer (`reclaim_en_i[i]`=1). `reclaimed_o` is 1 exactly for grants made to a requester other than the slot's owner.
- R6: Competing reclaimers receive spare slots in rotating order. The search starts just after the last reclaim winner. Only reclaim grants move this pointer; owner grants leave it unchanged.
- R7: A single requesting reclaimer receives every spare slot.
- R8: While `reclaim_off_i` is 1, grants equal pure time-division and `reclaimed_o` stays 0.
- R9: If all requesters are reclaimers and all request, each one is granted only in its own slot, once per eight clocks.
- R10: During reset `grant_o`=0, `reclaimed_o`=0 and `slot_o`=7. The slot counter starts at 0 and the reclaim pointer at requester 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request line per requester |
| reclaim_en_i | input | 8 | Per-requester mode: 1 = reclaimer, 0 = compliant |
| reclaim_off_i | input | 1 | Global reclaim disable (forces all compliant) |
| grant_o | output | 8 | Registered one-hot grant |
| slot_o | output | 3 | Slot index the current grant belongs to |
| reclaimed_o | output | 1 | Grant went to a non-owner through reclaim |

## Verification
The bench targets the rotation pointer, with three reclaimers asking continuously across two full wheel turns. A design that moved the pointer on owner grants, or always searched from requester 0, would hand out 0,0,0… or skip a requester instead of 0,1,2,0,1,2.

It also drives the owner and a reclaimer in the same slot. A priority inversion would show up as a reclaim flag in an owner's slot.

The global disable is tested with many reclaimers requesting. A disable that was not applied would fill the spare slots. A compliant requester that stays idle must leave the spare slots empty, which exposes a mask that ignores the mode bits.

// File: rtl/hub_arb_pkg.sv
package hub_arb_pkg;

    // Default number of requesters sharing the port (also the wheel length).
    localparam int unsigned DEF_REQ = 8;

    // How the registered grant was obtained.
    typedef enum logic [1:0] {
        GK_NONE    = 2'd0,
        GK_OWNER   = 2'd1,
        GK_RECLAIM = 2'd2
    } grant_kind_e;

endpackage

// File: rtl/slot_wheel.sv
module slot_wheel #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [IW-1:0] slot_o
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [IW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign slot_o = cnt_q;

endmodule

// File: rtl/reclaim_pick.sv
module reclaim_pick #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 3
) (
    input  logic [N-1:0]  cand_i,
    input  logic [IW-1:0] ptr_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    // Rotating-priority search: the candidate with the smallest cyclic
    // distance from ptr_i wins. Walking the offsets downward lets the
    // nearest hit overwrite the farther ones.
    logic [IW:0] pos_v;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        pos_v   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            pos_v = {1'b0, ptr_i} + (IW+1)'(k);
            if (pos_v >= (IW+1)'(N)) pos_v = pos_v - (IW+1)'(N);
            if (cand_i[pos_v[IW-1:0]]) begin
                found_o = 1'b1;
                idx_o   = pos_v[IW-1:0];
            end
        end
    end

endmodule

// File: rtl/hub_slot_arbiter.sv
module hub_slot_arbiter
    import hub_arb_pkg::*;
#(
    parameter  int unsigned NUM_REQ = DEF_REQ,
    localparam int unsigned IDX_W   = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [NUM_REQ-1:0] reclaim_en_i,
    input  logic               reclaim_off_i,
    output logic [NUM_REQ-1:0] grant_o,
    output logic [IDX_W-1:0]   slot_o,
    output logic               reclaimed_o
);

    localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(NUM_REQ - 1);
    localparam logic [NUM_REQ-1:0] ONE_HOT0 = NUM_REQ'(1);

    typedef struct packed {
        logic [NUM_REQ-1:0] grant;
        logic [IDX_W-1:0]   slot;
        grant_kind_e        kind;
        logic [IDX_W-1:0]   ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [IDX_W-1:0]   cur_slot;
    logic [NUM_REQ-1:0] owner_mask;
    logic [NUM_REQ-1:0] spare_cand;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;

    slot_wheel #(.N(NUM_REQ), .IW(IDX_W)) u_wheel (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (cur_slot)
    );

    assign owner_mask = ONE_HOT0 << cur_slot;
    // Opted-in requesters only, never the owner, nothing while disabled.
    assign spare_cand = req_i & reclaim_en_i & ~owner_mask
                      & {NUM_REQ{~reclaim_off_i}};

    reclaim_pick #(.N(NUM_REQ), .IW(IDX_W)) u_pick (
        .cand_i  (spare_cand),
        .ptr_i   (st_q.ptr),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.slot  = cur_slot;
        st_d.grant = '0;
        st_d.kind  = GK_NONE;
        if (|(req_i & owner_mask)) begin
            st_d.grant = owner_mask;
            st_d.kind  = GK_OWNER;
        end else if (pick_found) begin
            st_d.grant = ONE_HOT0 << pick_idx;
            st_d.kind  = GK_RECLAIM;
            st_d.ptr   = (pick_idx == LAST_IDX) ? '0 : pick_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.grant <= '0;
            st_q.slot  <= LAST_IDX;
            st_q.kind  <= GK_NONE;
            st_q.ptr   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o     = st_q.grant;
    assign slot_o      = st_q.slot;
    assign reclaimed_o = (st_q.kind == GK_RECLAIM);

endmodule

// File: rtl/hub_arb_checker.sv
module hub_arb_checker #(
    parameter int unsigned NUM_REQ = 8,
    parameter int unsigned IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] req_i,
    input logic [NUM_REQ-1:0] reclaim_en_i,
    input logic               reclaim_off_i,
    input logic [NUM_REQ-1:0] grant_o,
    input logic [IDX_W-1:0]   slot_o,
    input logic               reclaimed_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REQ - 1);

    logic [NUM_REQ-1:0] slot_mask;
    logic               live_q;

    assign slot_mask = NUM_REQ'(1) << slot_o;

    // High once a decision made out of reset is on the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R3

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (slot_o == (($past(slot_o) == LAST_IDX) ? '0 : $past(slot_o) + 1'b1))); // R1

    AST_OWNER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && |($past(req_i) & slot_mask)) |-> (grant_o == slot_mask)); // R2

    AST_FLAG_NOT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        reclaimed_o |-> ((grant_o != '0) && ((grant_o & slot_mask) == '0))); // R5

    AST_RECLAIM_OPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && reclaimed_o) |-> ((grant_o & $past(reclaim_en_i)) != '0)); // R4

    AST_DISABLE_TDM: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(reclaim_off_i)) |-> !reclaimed_o); // R8

endmodule

bind hub_slot_arbiter hub_arb_checker #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .reclaim_en_i  (reclaim_en_i),
    .reclaim_off_i (reclaim_off_i),
    .grant_o       (grant_o),
    .slot_o        (slot_o),
    .reclaimed_o   (reclaimed_o)
);

// File: tb/test_hub_slot_arbiter.sv
`timescale 1ns/1ps
module test_hub_slot_arbiter;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req, en;
    logic       off;
    logic [7:0] grant;
    logic [2:0] slot;
    logic       recl;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    hub_slot_arbiter i_hub_slot_arbiter (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .reclaim_en_i  (en),
        .reclaim_off_i (off),
        .grant_o       (grant),
        .slot_o        (slot),
        .reclaimed_o   (recl)
    );

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] en;
        logic       off;
        logic [7:0] g;
        logic       rc;
    } vec_t;

    // Walked from reset: entry k is decided in slot k mod 8.
    localparam vec_t VECS [16] = '{
        '{8'h01, 8'h00, 1'b0, 8'h01, 1'b0},  // s0 owner            R2
        '{8'h00, 8'h00, 1'b0, 8'h00, 1'b0},  // s1 idle
        '{8'h01, 8'h00, 1'b0, 8'h00, 1'b0},  // s2 compliant waits  R4
        '{8'h01, 8'h01, 1'b0, 8'h01, 1'b1},  // s3 reclaim by 0     R5 R10 ptr->1
        '{8'h11, 8'h01, 1'b0, 8'h10, 1'b0},  // s4 owner beats      R2
        '{8'h03, 8'h03, 1'b0, 8'h02, 1'b1},  // s5 ptr1 -> 1        R6 ptr->2
        '{8'h03, 8'h03, 1'b0, 8'h01, 1'b1},  // s6 wraps to 0       R6 ptr->1
        '{8'h03, 8'h03, 1'b1, 8'h00, 1'b0},  // s7 disabled         R8
        '{8'h03, 8'h03, 1'b0, 8'h01, 1'b0},  // s0 owner, ptr kept  R6
        '{8'h02, 8'h03, 1'b0, 8'h02, 1'b0},  // s1 owner
        '{8'h03, 8'h03, 1'b0, 8'h02, 1'b1},  // s2 ptr still 1      R6 ptr->2
        '{8'h80, 8'h80, 1'b0, 8'h80, 1'b1},  // s3 reclaim by 7     R7 ptr->0
        '{8'hFF, 8'hFF, 1'b0, 8'h10, 1'b0},  // s4 all busy         R9
        '{8'hEF, 8'hFF, 1'b0, 8'h20, 1'b0},  // s5 owner            R2
        '{8'h01, 8'hFF, 1'b1, 8'h00, 1'b0},  // s6 disabled         R8
        '{8'h81, 8'h7F, 1'b0, 8'h80, 1'b0}   // s7 owner compliant  R4
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; en = '0; off = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 reset grant",     32'(grant), 32'h0);
        check("R10 reset reclaimed", 32'(recl),  32'h0);
        check("R10 reset slot",      32'(slot),  32'h7);
        rst_n = 1'b1;
        cyc   = 0;
    endtask

    // Drive at a falling edge, decision at the rising edge, sample next fall.
    task automatic step(input logic [7:0] r, input logic [7:0] e, input logic o,
                        input logic [7:0] exp_g, input logic exp_rc, input string tag);
        req = r; en = e; off = o;
        @(negedge clk);
        check({tag, " grant"},     32'(grant), 32'(exp_g));
        check({tag, " reclaimed"}, 32'(recl),  32'(exp_rc));
        check("R1 slot",           32'(slot),  32'(cyc % 8));
        cyc++;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req = '0; en = '0; off = 1'b0;
        do_reset();

        for (int k = 0; k < 16; k++)
            step(VECS[k].req, VECS[k].en, VECS[k].off, VECS[k].g, VECS[k].rc,
                 $sformatf("table[%0d] R2 R4 R5 R6 R8", k));

        // R6: three reclaimers, two wheel turns, from a fresh pointer (R10)
        do_reset();
        begin
            int rr = 0;
            for (int c = 0; c < 16; c++) begin
                if ((c % 8) < 3) step(8'h07, 8'h07, 1'b0, 8'(1 << (c % 8)), 1'b0, "R6 owner");
                else begin
                    step(8'h07, 8'h07, 1'b0, 8'(1 << rr), 1'b1, "R6 rotation");
                    rr = (rr + 1) % 3;
                end
            end
        end

        // R7: lone reclaimer takes every spare slot
        for (int c = 0; c < 8; c++)
            step(8'h20, 8'h20, 1'b0, 8'h20, (c != 5), "R7 single");

        // R9: everyone reclaiming and busy
        for (int c = 0; c < 8; c++)
            step(8'hFF, 8'hFF, 1'b0, 8'(1 << c), 1'b0, "R9 all busy");

        // R8: global disable gives pure slot wheel
        for (int c = 0; c < 8; c++)
            step(8'h01, 8'hFF, 1'b1, (c == 0) ? 8'h01 : 8'h00, 1'b0, "R8 disable");

        // R4: compliant requester only in its own slot
        for (int c = 0; c < 8; c++)
            step(8'h40, 8'h00, 1'b0, (c == 6) ? 8'h40 : 8'h00, 1'b0, "R4 compliant");

        // R3: grant drops the cycle after requests stop
        step(8'h00, 8'h00, 1'b0, 8'h00, 1'b0, "R3 latency");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule